// File: doc/BRIEF.md
# Ramp Crossing Amplitude Digitizer

This block turns per-channel comparator bits into amplitude codes. Every channel's comparator compares its analog input against one shared reference that climbs over a fixed window and then descends over a second window of the same length. A fine timestamp input advances once per time quantum. A strobe marks the start of each ramp cycle. The block records the time at which each comparator flips: downward while the reference climbs, upward while it descends.

Both times go through a writable per-channel calibration table, which absorbs a nonlinear ramp, and come out as amplitude codes. A channel that never flips inside a window is reported at a saturated code with an overflow flag. Each ramp cycle produces a stream of samples. All climb-window samples come first, in ascending channel order, and the descent-window samples follow in the same order. The timestamp source, the ramp generator and the comparators are outside the block.

Top module: `ramp_digitizer`

## Requirements
- R1: A comparator fall (1 to 0) first observed at a clock edge whose relative time `t` is inside the climb window `0 <= t < 2**CW` gives a climb sample with raw time code `t`. Relative time is 0 at the clock edge that has `cycle_start` high, and it advances with `tstamp` after that edge.
- R2: A comparator rise (0 to 1) first observed at relative time `2**CW + d` inside the descent window `0 <= d < 2**CW` gives a descent sample with raw code `2**CW - 1 - d`.
- R3: A window with no accepted crossing gives a sample with `out_ovf` = 1. Its code is all ones if the comparator level at the last time bin of the window was 1, and zero otherwise. This code does not go through the calibration table. Samples with a crossing have `out_ovf` = 0.
- R4: Only the first crossing of the accepted polarity in each window counts. Any later transitions in the same window leave the sample unchanged.
- R5: Transitions of the wrong polarity are ignored. So are transitions in the interval after the descent window and transitions before any `cycle_start`. None of these adds or changes a sample.
- R6: Each channel has 2**SEG_BITS table entries, indexed by the top SEG_BITS bits of the raw code. The output code is min(entry + low CW-SEG_BITS bits of raw, 2**CW-1). A write (`cal_we`) changes only the addressed channel and segment.
- R7: Climb samples for channels 0..NCH-1 appear on consecutive cycles. Channel 0 is valid after the clock edge at relative time `2**CW + 1`. Descent samples follow the same pattern, starting after the edge at relative time `2**CW*2 + 1`. `out_edge` is 0 for climb samples and 1 for descent samples.
- R8: After reset `out_valid` is 0, and every table entry holds `segment << (CW-SEG_BITS)`, so the output code equals the raw code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | Strobe marking relative time 0 of a ramp cycle |
| tstamp | input | TSW | Fine timestamp, one count per time quantum |
| comp | input | NCH | Comparator outputs, one per channel |
| cal_we | input | 1 | Calibration table write enable |
| cal_ch | input | CHW | Channel of the table write |
| cal_seg | input | SEG_BITS | Segment of the table write |
| cal_base | input | CW | Value written to the table entry |
| out_valid | output | 1 | Sample valid |
| out_chan | output | CHW | Channel of the sample |
| out_edge | output | 1 | 0 = climb window sample, 1 = descent window sample |
| out_code | output | CW | Calibrated or saturated amplitude code |
| out_ovf | output | 1 | No crossing was found in the window |

## Verification
The bench builds the block with NCH=3, CW=6, SEG_BITS=3 and TSW=8. Each window is then 64 bins long, so a whole ramp cycle takes under 150 clocks. Crossings at the first and last bin of both windows, and clipping at the top of the table, can be reached directly. With three channels, the channel index is not a power of two and must stop at the right value. The 8-bit timestamp wraps during the run, so time is measured relative to the latched start and not from an absolute count.

// File: rtl/rd_pkg.sv
package rd_pkg;
  // Which ramp window a sample belongs to.
  typedef enum logic {
    EDGE_UP = 1'b0,
    EDGE_DN = 1'b1
  } edge_e;
endpackage

// File: rtl/rd_phase.sv
// Tracks relative time since the cycle strobe and names the windows.
module rd_phase #(
  parameter int CW  = 12,
  parameter int TSW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cycle_start,
  input  logic [TSW-1:0] tstamp,
  output logic           in_up,
  output logic           in_dn,
  output logic           up_end,
  output logic           dn_end,
  output logic [CW-1:0]  tcode
);
  localparam int UPB = 1 << CW;

  logic [TSW-1:0] base_q;
  logic [TSW-1:0] rel;
  logic           armed_q, was_up_q, was_dn_q, armed_eff;
  int             rel_i;

  always_comb begin
    rel       = cycle_start ? '0 : tstamp - base_q;
    rel_i     = int'(rel);
    armed_eff = armed_q | cycle_start;
    in_up     = armed_eff && (rel_i < UPB);
    in_dn     = armed_eff && (rel_i >= UPB) && (rel_i < 2 * UPB);
    up_end    = was_up_q && !in_up;
    dn_end    = was_dn_q && !in_dn;
    tcode     = rel[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      armed_q  <= 1'b0;
      was_up_q <= 1'b0;
      was_dn_q <= 1'b0;
    end else begin
      if (cycle_start) base_q <= tstamp;
      if (cycle_start)  armed_q <= 1'b1;
      else if (dn_end)  armed_q <= 1'b0;
      was_up_q <= in_up;
      was_dn_q <= in_dn;
    end
  end

  // R2: the descent window is only entered straight from the climb window
  p_dn_after_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_dn) && !cycle_start) |-> $past(in_up));
endmodule

// File: rtl/rd_chan_capture.sv
// One channel: first-crossing capture in each window, saturation at window end.
module rd_chan_capture #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          comp,
  input  logic          clr,
  input  logic          in_up,
  input  logic          in_dn,
  input  logic          up_end,
  input  logic          dn_end,
  input  logic [CW-1:0] tcode,
  output logic [CW-1:0] up_code,
  output logic          up_ovf,
  output logic [CW-1:0] dn_code,
  output logic          dn_ovf
);
  logic comp_q, up_done_q, dn_done_q;
  logic fall, rise, up_hit, dn_hit, up_sat, dn_sat;

  always_comb begin
    fall   = comp_q & ~comp;
    rise   = ~comp_q & comp;
    up_hit = in_up && fall && (clr || !up_done_q);
    dn_hit = in_dn && rise && (clr || !dn_done_q);
    up_sat = up_end && !up_done_q;
    dn_sat = dn_end && !dn_done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q    <= 1'b0;
      up_done_q <= 1'b0;
      dn_done_q <= 1'b0;
      up_code   <= '0;
      up_ovf    <= 1'b0;
      dn_code   <= '0;
      dn_ovf    <= 1'b0;
    end else begin
      comp_q <= comp;
      if (clr) begin
        up_done_q <= 1'b0;
        dn_done_q <= 1'b0;
      end
      if (up_hit) begin
        up_code   <= tcode;
        up_ovf    <= 1'b0;
        up_done_q <= 1'b1;
      end else if (up_sat) begin
        up_code   <= {CW{comp_q}};
        up_ovf    <= 1'b1;
        up_done_q <= 1'b1;
      end
      if (dn_hit) begin
        dn_code   <= ~tcode;
        dn_ovf    <= 1'b0;
        dn_done_q <= 1'b1;
      end else if (dn_sat) begin
        dn_code   <= {CW{comp_q}};
        dn_ovf    <= 1'b1;
        dn_done_q <= 1'b1;
      end
    end
  end

  // R4: once a window has its crossing, the code holds until the next cycle
  p_hold_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_done_q && !clr) |=> $stable(up_code));
  p_hold_dn_after_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_done_q && !clr) |=> $stable(dn_code));
  // R5: outside its window a code never moves
  p_up_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_up && !up_end) |=> $stable(up_code));
  // R3: an overflow sample carries a saturated code
  p_ovf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_ovf |-> (up_code == '0 || up_code == '1));
endmodule

// File: rtl/rd_cal_table.sv
// Per-channel segment table: code = min(entry[seg] + low bits, full scale).
module rd_cal_table #(
  parameter int NCH      = 8,
  parameter int CW       = 12,
  parameter int SEG_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CHW-1:0]      wr_ch,
  input  logic [SEG_BITS-1:0] wr_seg,
  input  logic [CW-1:0]       wr_base,
  input  logic [CHW-1:0]      rd_ch,
  input  logic [CW-1:0]       rd_raw,
  output logic [CW-1:0]       rd_code
);
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NSEG = 1 << SEG_BITS;
  localparam int LOWB = CW - SEG_BITS;
  localparam logic [CW-1:0] LOW_MASK = CW'((1 << LOWB) - 1);

  logic [CW-1:0] base_q [NCH][NSEG];

  function automatic logic [CW-1:0] apply_cal(input logic [CW-1:0] base,
                                              input logic [CW-1:0] raw);
    logic [CW:0] sum;
    sum = {1'b0, base} + {1'b0, raw & LOW_MASK};
    return sum[CW] ? '1 : sum[CW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int s = 0; s < NSEG; s++)
          base_q[c][s] <= CW'(s << LOWB);
    end else if (we) begin
      base_q[wr_ch][wr_seg] <= wr_base;
    end
  end

  assign rd_code = apply_cal(base_q[rd_ch][rd_raw[CW-1 -: SEG_BITS]], rd_raw);

  // R6: a write lands in exactly the addressed entry
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (base_q[$past(wr_ch)][$past(wr_seg)] == $past(wr_base)));
endmodule

// File: rtl/ramp_digitizer.sv
module ramp_digitizer #(
  parameter int NCH      = 8,
  parameter int CW       = 12,
  parameter int SEG_BITS = 5,
  parameter int TSW      = 14,
  localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cycle_start,
  input  logic [TSW-1:0]      tstamp,
  input  logic [NCH-1:0]      comp,
  input  logic                cal_we,
  input  logic [CHW-1:0]      cal_ch,
  input  logic [SEG_BITS-1:0] cal_seg,
  input  logic [CW-1:0]       cal_base,
  output logic                out_valid,
  output logic [CHW-1:0]      out_chan,
  output logic                out_edge,
  output logic [CW-1:0]       out_code,
  output logic                out_ovf
);
  import rd_pkg::*;
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  logic          in_up, in_dn, up_end, dn_end;
  logic [CW-1:0] tcode;
  logic [CW-1:0] up_code_a [NCH];
  logic [CW-1:0] dn_code_a [NCH];
  logic          up_ovf_a  [NCH];
  logic          dn_ovf_a  [NCH];

  rd_phase #(.CW(CW), .TSW(TSW)) u_phase (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .tstamp(tstamp),
    .in_up(in_up), .in_dn(in_dn), .up_end(up_end), .dn_end(dn_end), .tcode(tcode));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rd_chan_capture #(.CW(CW)) u_cap (
      .clk(clk), .rst_n(rst_n), .comp(comp[c]), .clr(cycle_start),
      .in_up(in_up), .in_dn(in_dn), .up_end(up_end), .dn_end(dn_end), .tcode(tcode),
      .up_code(up_code_a[c]), .up_ovf(up_ovf_a[c]),
      .dn_code(dn_code_a[c]), .dn_ovf(dn_ovf_a[c]));
  end

  // Serializer: one sample per clock, channels ascending.
  logic           go_up_q, go_dn_q, busy_q, go_any, emitting, last;
  logic [CHW-1:0] idx_q, cur_idx;
  edge_e          edge_q, cur_edge, out_edge_q;
  logic [CW-1:0]  raw_sel, cal_code;
  logic           ovf_sel;

  always_comb begin
    go_any   = go_up_q | go_dn_q;
    emitting = go_any | busy_q;
    cur_idx  = go_any ? '0 : idx_q;
    cur_edge = go_dn_q ? EDGE_DN : (go_up_q ? EDGE_UP : edge_q);
    raw_sel  = (cur_edge == EDGE_DN) ? dn_code_a[cur_idx] : up_code_a[cur_idx];
    ovf_sel  = (cur_edge == EDGE_DN) ? dn_ovf_a[cur_idx]  : up_ovf_a[cur_idx];
    last     = (cur_idx == LAST);
  end

  rd_cal_table #(.NCH(NCH), .CW(CW), .SEG_BITS(SEG_BITS)) u_cal (
    .clk(clk), .rst_n(rst_n), .we(cal_we), .wr_ch(cal_ch), .wr_seg(cal_seg),
    .wr_base(cal_base), .rd_ch(cur_idx), .rd_raw(raw_sel), .rd_code(cal_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_up_q    <= 1'b0;
      go_dn_q    <= 1'b0;
      busy_q     <= 1'b0;
      idx_q      <= '0;
      edge_q     <= EDGE_UP;
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_edge_q <= EDGE_UP;
      out_code   <= '0;
      out_ovf    <= 1'b0;
    end else begin
      go_up_q   <= up_end;
      go_dn_q   <= dn_end;
      out_valid <= emitting;
      busy_q    <= emitting && !last;
      idx_q     <= cur_idx + CHW'(1);
      edge_q    <= cur_edge;
      if (emitting) begin
        out_chan   <= cur_idx;
        out_edge_q <= cur_edge;
        out_code   <= ovf_sel ? raw_sel : cal_code;
        out_ovf    <= ovf_sel;
      end
    end
  end

  assign out_edge = out_edge_q;

  // R7: a burst starts at channel 0 and steps by one inside one window type
  p_first_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_chan == '0));
  p_chan_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_chan != LAST) |=> (out_valid && out_chan == $past(out_chan) + CHW'(1)));
  p_group_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_chan != LAST) |=> (out_edge == $past(out_edge)));
  // R3: overflow samples leave the block saturated
  p_no_overflow_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_code == '0 || out_code == '1));
endmodule

// File: tb/ramp_digitizer_bench.sv
module ramp_digitizer_bench;
  localparam int NCH = 3, CW = 6, SEG_BITS = 3, TSW = 8;
  localparam int CHW = 2, UPB = 1 << CW, CYC = 2 * UPB + 16, LOWB = CW - SEG_BITS;

  logic clk = 0, rst_n = 0, cycle_start = 0, cal_we = 0;
  logic [TSW-1:0] tstamp = 8'd200;
  logic [NCH-1:0] comp = '1;
  logic [CHW-1:0] cal_ch = '0;
  logic [SEG_BITS-1:0] cal_seg = '0;
  logic [CW-1:0] cal_base = '0;
  logic out_valid, out_edge, out_ovf;
  logic [CHW-1:0] out_chan;
  logic [CW-1:0] out_code;

  int nchk = 0, nerr = 0;
  logic wave [NCH][CYC];
  int cal_m [NCH][1 << SEG_BITS];

  ramp_digitizer #(.NCH(NCH), .CW(CW), .SEG_BITS(SEG_BITS), .TSW(TSW)) u_ramp_digitizer (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .tstamp(tstamp), .comp(comp),
    .cal_we(cal_we), .cal_ch(cal_ch), .cal_seg(cal_seg), .cal_base(cal_base),
    .out_valid(out_valid), .out_chan(out_chan), .out_edge(out_edge),
    .out_code(out_code), .out_ovf(out_ovf));

  always #4 clk = ~clk;
  initial forever begin
    @(negedge clk);
    tstamp <= tstamp + 8'd1;
  end

  task automatic check(string what, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  function automatic int cal_ref(int ch, int raw);
    int v;
    v = cal_m[ch][raw / (1 << LOWB)] + raw % (1 << LOWB);
    return (v > UPB - 1) ? UPB - 1 : v;
  endfunction

  function automatic void expect_sample(int ch, bit dn, logic prev0, output int code, output int ovf);
    int lo, hit;
    logic p;
    lo = dn ? UPB : 0;
    hit = -1;
    for (int t = lo; t < lo + UPB; t++) begin
      p = (t == 0) ? prev0 : wave[ch][t-1];
      if (hit < 0 && ((!dn && p && !wave[ch][t]) || (dn && !p && wave[ch][t]))) hit = t;
    end
    if (hit >= 0) begin
      ovf = 0;
      code = cal_ref(ch, dn ? (UPB - 1 - (hit - UPB)) : hit);
    end else begin
      ovf = 1;
      code = wave[ch][lo + UPB - 1] ? UPB - 1 : 0;
    end
  endfunction

  task automatic set_lvl(int ch, int t0, int t1, logic v);
    for (int t = t0; t < t1; t++) wave[ch][t] = v;
  endtask

  task automatic idle(logic [NCH-1:0] lvl, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      comp = lvl;
    end
  endtask

  task automatic cal_write(int ch, int seg, int base);
    @(negedge clk);
    cal_we = 1; cal_ch = CHW'(ch); cal_seg = SEG_BITS'(seg); cal_base = CW'(base);
    @(negedge clk);
    cal_we = 0;
    cal_m[ch][seg] = base;
  endtask

  // Plays one ramp cycle from wave[] and checks every emitted sample.
  task automatic play_cycle(string rq);
    int n, code, ovf;
    int rt[16], rch[16], re[16], rc[16], ro[16];
    logic [NCH-1:0] start_lvl;
    start_lvl = comp;
    n = 0;
    for (int t = 0; t < CYC; t++) begin
      @(negedge clk);
      if (out_valid && n < 16) begin
        rt[n] = t - 1; rch[n] = int'(out_chan); re[n] = int'(out_edge);
        rc[n] = int'(out_code); ro[n] = int'(out_ovf); n++;
      end
      cycle_start = (t == 0);
      for (int c = 0; c < NCH; c++) comp[c] = wave[c][t];
    end
    check({rq, " R7 sample count"}, n, 2 * NCH);
    for (int k = 0; k < 2 * NCH; k++) begin
      expect_sample(k % NCH, k >= NCH, start_lvl[k % NCH], code, ovf);
      if (k < n) begin
        check($sformatf("%s R7 time of sample %0d", rq, k), rt[k],
              (k < NCH) ? UPB + 1 + k : 2 * UPB + 1 + k - NCH);
        check($sformatf("%s R7 channel of sample %0d", rq, k), rch[k], k % NCH);
        check($sformatf("%s R7 edge of sample %0d", rq, k), re[k], (k >= NCH) ? 1 : 0);
        check($sformatf("%s code ch%0d edge%0d", rq, k % NCH, k / NCH), rc[k], code);
        check($sformatf("%s R3 ovf ch%0d edge%0d", rq, k % NCH, k / NCH), ro[k], ovf);
      end
    end
  endtask

  task automatic t_reset;
    int seen;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 out_valid after reset", int'(out_valid), 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      comp = NCH'(i % 5);
      if (out_valid) seen++;
    end
    check("R5 edges before any cycle_start give no sample", seen, 0);
    idle('1, 3);
  endtask

  task automatic t_basic;
    set_lvl(0, 0, 10, 1); set_lvl(0, 10, 84, 0); set_lvl(0, 84, CYC, 1);
    set_lvl(1, 0, 63, 1); set_lvl(1, 63, 64, 0); set_lvl(1, 64, CYC, 1);
    set_lvl(2, 0, 127, 0); set_lvl(2, 127, CYC, 1);
    play_cycle("R1 R2 R8 basic");
  endtask

  task automatic t_saturate;
    idle(3'b101, 3);
    set_lvl(0, 0, CYC, 1);
    set_lvl(1, 0, CYC, 0);
    set_lvl(2, 0, 40, 1); set_lvl(2, 40, CYC, 0);
    play_cycle("R3 saturate");
  endtask

  task automatic t_glitch;
    idle(3'b101, 3);
    set_lvl(0, 0, 5, 1); set_lvl(0, 5, 8, 0); set_lvl(0, 8, 9, 1); set_lvl(0, 9, 67, 0);
    set_lvl(0, 67, 74, 1); set_lvl(0, 74, 75, 0); set_lvl(0, 75, CYC, 1);
    set_lvl(1, 0, 20, 0); set_lvl(1, 20, 30, 1); set_lvl(1, 30, 70, 0);
    set_lvl(1, 70, 75, 1); set_lvl(1, 75, 90, 0); set_lvl(1, 90, CYC, 1);
    set_lvl(2, 0, 50, 1); set_lvl(2, 50, 100, 0); set_lvl(2, 100, 2 * UPB, 1);
    for (int t = 2 * UPB; t < CYC; t++) wave[2][t] = t[0];
    play_cycle("R4 R5 glitch");
  endtask

  task automatic t_cal;
    idle('1, 3);
    cal_write(1, 2, 40);
    cal_write(2, 7, 60);
    set_lvl(0, 0, 20, 1); set_lvl(0, 20, UPB + 43, 0); set_lvl(0, UPB + 43, CYC, 1);
    set_lvl(1, 0, 20, 1); set_lvl(1, 20, UPB + 47, 0); set_lvl(1, UPB + 47, CYC, 1);
    set_lvl(2, 0, 60, 1); set_lvl(2, 60, UPB, 0); set_lvl(2, UPB, CYC, 1);
    play_cycle("R6 calibration");
    check("R6 ch1 segment 2 entry used", cal_ref(1, 20), 44);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < (1 << SEG_BITS); s++) cal_m[c][s] = s << LOWB;
    t_reset();
    t_basic();
    t_saturate();
    t_glitch();
    t_cal();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule